// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Near-Empty and Near-Full Flags

A 9-bit-wide first-in first-out buffer whose write side and read side run on independent clocks. Four active-low status flags report the fill level: empty and near-empty are produced in the read clock domain, and full and near-full are produced in the write clock domain. Both domains exchange their pointers as gray codes through two-stage synchronisers.

An auxiliary control pin has two possible roles, and the level it holds while reset is asserted picks the role. If it is held high, the pin acts as a second write enable. If it is held low, the pin becomes a load strobe. While this strobe is low, write-clock edges that have the primary write enable asserted store the data input into the threshold registers. Read-clock edges that have both read enables asserted copy a threshold register to the data output. The loads and the readbacks each alternate between the near-empty threshold and the near-full threshold, and each sequence starts with near-empty. An output-enable input gates the data output bus.

Top module: `fifo_pf_top`

## Requirements
- R1: Words come out in the order they were written, with all 9 bits intact.
- R2: After reset the FIFO is empty. emptyN and nearEmptyN are 0, fullN and nearFullN are 1, and both thresholds are 7.
- R3: emptyN and nearEmptyN change only on rising rdClk edges. fullN and nearFullN change only on rising wrClk edges.
- R4: A word is stored on a rising wrClk edge when wrEnAN is 0, auxPin is 1 and fullN is 1. A write attempted while fullN is 0 leaves the contents and the count unchanged.
- R5: A word is removed on a rising rdClk edge when rdEnAN and rdEnBN are both 0 and emptyN is 1. emptyN is 0 exactly when the count is 0. A read while empty leaves dataOut unchanged.
- R6: nearEmptyN is 0 exactly when the word count is less than or equal to the near-empty threshold.
- R7: nearFullN is 0 exactly when DEPTH minus the count is less than or equal to the near-full threshold. fullN is 0 exactly when the count equals DEPTH.
- R8: If auxPin is high during reset, it acts as a second write enable afterwards, so a write with auxPin at 0 stores nothing.
- R9: If auxPin is low during reset, then each wrClk edge with auxPin at 0 and wrEnAN at 0 loads dIn (its low threshold-width bits) into a threshold register instead of the memory. The first load goes to near-empty, the next to near-full, and the pattern alternates from there.
- R10: In load mode, each rdClk edge with auxPin at 0 and both read enables at 0 places a threshold on dataOut, zero-extended. The order is near-empty first, then alternating. No word is removed.
- R11: With outEnN at 1, busDrive is 0 and dataOut is all zeros. With outEnN at 0, busDrive is 1 and dataOut shows the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-domain clock |
| rdClk | input | 1 | Read-domain clock |
| rstN | input | 1 | Active-low reset, sampled synchronously in both domains |
| wrEnAN | input | 1 | Primary write enable, active low |
| auxPin | input | 1 | Second write enable or threshold load strobe; its role is latched during reset |
| dIn | input | DW | Write data and threshold load value |
| rdEnAN | input | 1 | Read enable A, active low |
| rdEnBN | input | 1 | Read enable B, active low |
| outEnN | input | 1 | Output enable, active low |
| dataOut | output | DW | Read data or threshold readback, zero while disabled |
| busDrive | output | 1 | High while the output bus is driven |
| emptyN | output | 1 | Empty flag, active low, read domain |
| nearEmptyN | output | 1 | Near-empty flag, active low, read domain |
| fullN | output | 1 | Full flag, active low, write domain |
| nearFullN | output | 1 | Near-full flag, active low, write domain |

## Verification
The bench builds the block with DEPTH set to 16, which gives a 4-bit threshold width. With that setting, 16 writes fill the FIFO, and the default thresholds of 7 fall near the middle of the range. As a result, every step of both near flags can be checked, along with the write attempted when full and the read attempted when empty. The two clocks run at unrelated periods. A second reset with auxPin low brings load mode into reach: the thresholds 3 and 5 are loaded, read back in alternating order, and the bench confirms that the flag edges move to match them.

// File: rtl/fifo_pf_pkg.sv
package fifo_pf_pkg;
  typedef struct packed {
    logic memWr;
    logic offWr;
    logic offSel;
  } wrStrobes_t;

  typedef struct packed {
    logic memRd;
    logic offRd;
    logic offSel;
  } rdStrobes_t;
endpackage

// File: rtl/fifo_pf_sync.sv
module fifo_pf_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/fifo_pf_ctrl.sv
module fifo_pf_ctrl
  import fifo_pf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int OFFW  = 6
) (
  input  logic            wrClk,
  input  logic            rdClk,
  input  logic            rstN,
  input  logic            wrEnAN,
  input  logic            auxPin,
  input  logic            rdEnAN,
  input  logic            rdEnBN,
  input  logic [OFFW-1:0] aeOff,
  input  logic [OFFW-1:0] afOff,
  output wrStrobes_t      wrStb,
  output rdStrobes_t      rdStb,
  output logic [AW-1:0]   wrAddr,
  output logic [AW-1:0]   rdAddr,
  output logic            emptyN,
  output logic            nearEmptyN,
  output logic            fullN,
  output logic            nearFullN
);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULLCNT = CW'(DEPTH);

  function automatic logic [CW-1:0] grayToBin(input logic [CW-1:0] g);
    logic [CW-1:0] b;
    b[CW-1] = g[CW-1];
    for (int i = CW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // write domain
  logic          loadModeW, offSelW;
  logic [CW-1:0] wrPtr, wrPtrNext, wrGray, rdGraySync, rdPtrW, wrCnt;

  fifo_pf_sync #(.W(CW)) u_rd2wr (
    .clk(wrClk), .rstN(rstN), .din(rdGray), .dout(rdGraySync)
  );

  always_comb begin
    wrStb.memWr  = !wrEnAN && auxPin && fullN;
    wrStb.offWr  = loadModeW && !auxPin && !wrEnAN;
    wrStb.offSel = offSelW;
    wrPtrNext    = wrPtr + CW'(wrStb.memWr);
    rdPtrW       = grayToBin(rdGraySync);
    wrCnt        = wrPtrNext - rdPtrW;
  end

  always_ff @(posedge wrClk) begin
    if (!rstN) begin
      loadModeW <= !auxPin;
      offSelW   <= 1'b0;
      wrPtr     <= '0;
      wrGray    <= '0;
      fullN     <= 1'b1;
      nearFullN <= 1'b1;
    end else begin
      offSelW   <= offSelW ^ wrStb.offWr;
      wrPtr     <= wrPtrNext;
      wrGray    <= wrPtrNext ^ (wrPtrNext >> 1);
      fullN     <= (wrCnt != FULLCNT);
      nearFullN <= ((FULLCNT - wrCnt) > CW'(afOff));
    end
  end

  // read domain
  logic          loadModeR, offSelR, rdReq;
  logic [CW-1:0] rdPtr, rdPtrNext, rdGray, wrGraySync, wrPtrR, rdCnt;

  fifo_pf_sync #(.W(CW)) u_wr2rd (
    .clk(rdClk), .rstN(rstN), .din(wrGray), .dout(wrGraySync)
  );

  always_comb begin
    rdReq        = !rdEnAN && !rdEnBN;
    rdStb.offRd  = loadModeR && !auxPin && rdReq;
    rdStb.memRd  = rdReq && emptyN && !rdStb.offRd;
    rdStb.offSel = offSelR;
    rdPtrNext    = rdPtr + CW'(rdStb.memRd);
    wrPtrR       = grayToBin(wrGraySync);
    rdCnt        = wrPtrR - rdPtrNext;
  end

  always_ff @(posedge rdClk) begin
    if (!rstN) begin
      loadModeR  <= !auxPin;
      offSelR    <= 1'b0;
      rdPtr      <= '0;
      rdGray     <= '0;
      emptyN     <= 1'b0;
      nearEmptyN <= 1'b0;
    end else begin
      offSelR    <= offSelR ^ rdStb.offRd;
      rdPtr      <= rdPtrNext;
      rdGray     <= rdPtrNext ^ (rdPtrNext >> 1);
      emptyN     <= (rdCnt != '0);
      nearEmptyN <= (rdCnt > CW'(aeOff));
    end
  end

  assign wrAddr = wrPtr[AW-1:0];
  assign rdAddr = rdPtr[AW-1:0];
endmodule

// File: rtl/fifo_pf_datapath.sv
module fifo_pf_datapath
  import fifo_pf_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int AW      = 6,
  parameter int DW      = 9,
  parameter int OFFW    = 6,
  parameter int DEF_OFF = 7
) (
  input  logic            wrClk,
  input  logic            rdClk,
  input  logic            rstN,
  input  wrStrobes_t      wrStb,
  input  rdStrobes_t      rdStb,
  input  logic [AW-1:0]   wrAddr,
  input  logic [AW-1:0]   rdAddr,
  input  logic [DW-1:0]   dIn,
  output logic [OFFW-1:0] aeOff,
  output logic [OFFW-1:0] afOff,
  output logic [DW-1:0]   dataQ
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (wrStb.memWr) mem[wrAddr] <= dIn;
  end

  always_ff @(posedge wrClk) begin
    if (!rstN) begin
      aeOff <= OFFW'(DEF_OFF);
      afOff <= OFFW'(DEF_OFF);
    end else if (wrStb.offWr) begin
      if (wrStb.offSel) afOff <= dIn[OFFW-1:0];
      else              aeOff <= dIn[OFFW-1:0];
    end
  end

  // thresholds are treated as quasi-static when seen from the read domain
  always_ff @(posedge rdClk) begin
    if (!rstN)            dataQ <= '0;
    else if (rdStb.memRd) dataQ <= mem[rdAddr];
    else if (rdStb.offRd) dataQ <= rdStb.offSel ? DW'(afOff) : DW'(aeOff);
  end
endmodule

// File: rtl/fifo_pf_top.sv
module fifo_pf_top
  import fifo_pf_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int DW      = 9,
  parameter int DEF_OFF = 7
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          wrEnAN,
  input  logic          auxPin,
  input  logic [DW-1:0] dIn,
  input  logic          rdEnAN,
  input  logic          rdEnBN,
  input  logic          outEnN,
  output logic [DW-1:0] dataOut,
  output logic          busDrive,
  output logic          emptyN,
  output logic          nearEmptyN,
  output logic          fullN,
  output logic          nearFullN
);
  localparam int AW   = $clog2(DEPTH);
  localparam int OFFW = (AW < DW) ? AW : DW;

  wrStrobes_t      wrStb;
  rdStrobes_t      rdStb;
  logic [AW-1:0]   wrAddr, rdAddr;
  logic [OFFW-1:0] aeOff, afOff;
  logic [DW-1:0]   dataQ;

  fifo_pf_ctrl #(.DEPTH(DEPTH), .AW(AW), .OFFW(OFFW)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEnAN(wrEnAN), .auxPin(auxPin), .rdEnAN(rdEnAN), .rdEnBN(rdEnBN),
    .aeOff(aeOff), .afOff(afOff),
    .wrStb(wrStb), .rdStb(rdStb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .emptyN(emptyN), .nearEmptyN(nearEmptyN), .fullN(fullN), .nearFullN(nearFullN)
  );

  fifo_pf_datapath #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .OFFW(OFFW), .DEF_OFF(DEF_OFF)) u_dp (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrStb(wrStb), .rdStb(rdStb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .dIn(dIn), .aeOff(aeOff), .afOff(afOff), .dataQ(dataQ)
  );

  assign busDrive = !outEnN;
  assign dataOut  = outEnN ? '0 : dataQ;
endmodule

// File: rtl/fifo_pf_chk.sv
module fifo_pf_chk #(
  parameter int AW = 6
) (
  input logic          wrClk,
  input logic          rdClk,
  input logic          rstN,
  input logic          emptyN,
  input logic          nearEmptyN,
  input logic          fullN,
  input logic          nearFullN,
  input logic [AW-1:0] wrAddr,
  input logic [AW-1:0] rdAddr
);
  a_r2_rd_reset_state: assert property (@(posedge rdClk) disable iff (!rstN)
    $rose(rstN) |-> (!emptyN && !nearEmptyN));
  a_r2_wr_reset_state: assert property (@(posedge wrClk) disable iff (!rstN)
    $rose(rstN) |-> (fullN && nearFullN));
  a_r4_full_blocks_write: assert property (@(posedge wrClk) disable iff (!rstN)
    !fullN |=> $stable(wrAddr));
  a_r5_empty_blocks_read: assert property (@(posedge rdClk) disable iff (!rstN)
    !emptyN |=> $stable(rdAddr));
  a_r6_empty_is_near_empty: assert property (@(posedge rdClk) disable iff (!rstN)
    !emptyN |-> !nearEmptyN);
  a_r7_full_is_near_full: assert property (@(posedge wrClk) disable iff (!rstN)
    !fullN |-> !nearFullN);

  always @(emptyN or nearEmptyN) begin
    if (rstN === 1'b1) a_r3_rd_flags_on_rdclk: assert (rdClk === 1'b1);
  end
  always @(fullN or nearFullN) begin
    if (rstN === 1'b1) a_r3_wr_flags_on_wrclk: assert (wrClk === 1'b1);
  end
endmodule

bind fifo_pf_top fifo_pf_chk #(.AW(AW)) u_chk (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
  .emptyN(emptyN), .nearEmptyN(nearEmptyN), .fullN(fullN), .nearFullN(nearFullN),
  .wrAddr(wrAddr), .rdAddr(rdAddr)
);

// File: tb/fifo_pf_top_tb.sv
module fifo_pf_top_tb;
  localparam int DEPTH = 16;
  localparam int DW    = 9;

  logic wrClk = 0, rdClk = 0, rstN = 0;
  logic wrEnAN = 1, auxPin = 1, rdEnAN = 1, rdEnBN = 1, outEnN = 0;
  logic [DW-1:0] dIn = '0;
  logic [DW-1:0] dataOut;
  logic busDrive, emptyN, nearEmptyN, fullN, nearFullN;
  int checks = 0, errors = 0;

  always #5 wrClk = ~wrClk;
  always #7 rdClk = ~rdClk;

  fifo_pf_top #(.DEPTH(DEPTH), .DW(DW)) u_dut (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrEnAN(wrEnAN), .auxPin(auxPin),
    .dIn(dIn), .rdEnAN(rdEnAN), .rdEnBN(rdEnBN), .outEnN(outEnN),
    .dataOut(dataOut), .busDrive(busDrive), .emptyN(emptyN), .nearEmptyN(nearEmptyN),
    .fullN(fullN), .nearFullN(nearFullN)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R3: flag edges must coincide with their own clock being high
  always @(emptyN or nearEmptyN) if (rstN === 1'b1) check("R3 read-side flag timing", int'(rdClk), 1);
  always @(fullN or nearFullN) if (rstN === 1'b1) check("R3 write-side flag timing", int'(wrClk), 1);

  task automatic doReset(input logic auxLvl);
    wrEnAN = 1; rdEnAN = 1; rdEnBN = 1; auxPin = auxLvl; rstN = 0;
    repeat (10) @(negedge wrClk);
    rstN = 1;
    repeat (4) @(negedge rdClk);
  endtask

  task automatic settle();
    repeat (8) @(negedge rdClk);
  endtask

  task automatic pushWord(input logic [DW-1:0] v);
    @(negedge wrClk); dIn = v; wrEnAN = 0;
    @(negedge wrClk); wrEnAN = 1;
  endtask

  task automatic popWord(output logic [DW-1:0] v);
    @(negedge rdClk); rdEnAN = 0; rdEnBN = 0;
    @(negedge rdClk); rdEnAN = 1; rdEnBN = 1;
    v = dataOut;
  endtask

  task automatic checkFlags(input string req, input int cnt, input int ae, input int af);
    check({req, " emptyN"},     int'(emptyN),     (cnt != 0) ? 1 : 0);
    check({req, " nearEmptyN"}, int'(nearEmptyN), (cnt <= ae) ? 0 : 1);
    check({req, " fullN"},      int'(fullN),      (cnt == DEPTH) ? 0 : 1);
    check({req, " nearFullN"},  int'(nearFullN),  ((DEPTH - cnt) <= af) ? 0 : 1);
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(i * 37 + 5);
  endfunction

  task automatic testReset();
    doReset(1'b1);
    checkFlags("R2 reset", 0, 7, 7);
  endtask

  task automatic testOrder();
    logic [DW-1:0] v;
    logic [DW-1:0] seq [5] = '{9'h1FF, 9'h000, 9'h155, 9'h0AA, 9'h101};
    for (int i = 0; i < 5; i++) pushWord(seq[i]);
    settle();
    for (int i = 0; i < 5; i++) begin
      popWord(v);
      check("R1 order", int'(v), int'(seq[i]));
    end
    settle();
    checkFlags("R5 drained", 0, 7, 7);
  endtask

  task automatic testFillDrain();
    logic [DW-1:0] v;
    for (int c = 1; c <= DEPTH; c++) begin
      pushWord(pat(c));
      settle();
      checkFlags("R6 R7 default fill", c, 7, 7);
    end
    pushWord(9'h1AB);
    settle();
    checkFlags("R4 write when full", DEPTH, 7, 7);
    for (int c = DEPTH - 1; c >= 0; c--) begin
      popWord(v);
      check("R4 R1 drain data", int'(v), int'(pat(DEPTH - c)));
      settle();
      checkFlags("R6 R7 default drain", c, 7, 7);
    end
    popWord(v);
    check("R5 read when empty keeps data", int'(dataOut), int'(pat(DEPTH)));
    settle();
    checkFlags("R5 read when empty", 0, 7, 7);
  endtask

  task automatic testSecondEnable();
    auxPin = 0;
    pushWord(9'h033);
    settle();
    checkFlags("R8 second enable blocks", 0, 7, 7);
    auxPin = 1;
    pushWord(9'h034);
    settle();
    checkFlags("R8 second enable allows", 1, 7, 7);
  endtask

  task automatic testLoadMode();
    logic [DW-1:0] v;
    doReset(1'b0);
    checkFlags("R2 reset load mode", 0, 7, 7);
    auxPin = 0;
    pushWord(9'h1F3);
    pushWord(9'h005);
    settle();
    checkFlags("R9 loads skip memory", 0, 3, 5);
    popWord(v); check("R10 readback near-empty", int'(v), 3);
    popWord(v); check("R10 readback near-full", int'(v), 5);
    auxPin = 1;
    for (int c = 1; c <= DEPTH; c++) begin
      pushWord(pat(c + 3));
      settle();
      checkFlags("R9 loaded thresholds", c, 3, 5);
    end
    auxPin = 0;
    popWord(v); check("R10 readback wraps", int'(v), 3);
    settle();
    checkFlags("R10 readback pops nothing", DEPTH, 3, 5);
    auxPin = 1;
    for (int c = DEPTH - 1; c >= 0; c--) begin
      popWord(v);
      check("R1 load mode data", int'(v), int'(pat(DEPTH - c + 3)));
    end
    settle();
    checkFlags("R9 drained", 0, 3, 5);
  endtask

  task automatic testOutputEnable();
    outEnN = 1; #1;
    check("R11 bus released", int'(busDrive), 0);
    check("R11 data masked", int'(dataOut), 0);
    outEnN = 0; #1;
    check("R11 bus driven", int'(busDrive), 1);
    check("R11 data shown", int'(dataOut), int'(pat(DEPTH + 3)));
  endtask

  initial begin
    testReset();
    testOrder();
    testFillDrain();
    testSecondEnable();
    testLoadMode();
    testOutputEnable();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule